// File: doc/BRIEF.md
# Priority-Arbitrated Clock Pulse Skipper

This block lowers the effective rate of two clock domains, a CPU clock and a GPU clock, by withholding a programmed share of their clock pulses. It does not gate the clocks itself. It produces one clock-enable bit per cycle for each domain, and a downstream gating cell uses that bit. Several throttle configurations can be requested at the same time, for example a heavy thermal one, a light thermal one and an over-current one. Each configuration has three settings: a numeric priority, a CPU skip percentage written directly, and a 2-bit GPU skip level.

An arbiter looks at the configurations whose active flag is set and picks the one with the largest priority. Equal priorities go to the lower index. The arbiter registers the chosen settings. Each skip engine samples them only at the last cycle of its 100-cycle window, so a change never produces a partial window. Inside a window, a fractional accumulator spreads the skipped pulses as evenly as it can.

All pins are plain control and status signals, sampled or driven on every cycle. No stream interface is present, so there is no valid/ready handshake and no back-pressure. The configuration inputs are level signals, and the block re-reads them on every cycle.

Top module: `thr_pulse_skipper`

## Requirements
- R1: While reset is asserted, `cpu_clk_en` and `gpu_clk_en` are 1. In the first cycle after reset, `win_start` is 1. The first window passes every pulse.
- R2: `win_start` is 1 for exactly one cycle in every 100 cycles. Each window is the 100 cycles that begin with that cycle.
- R3: When no configuration is active, both enables stay at 1 for the whole window.
- R4: When one or more configurations are active, the active one with the largest priority supplies both the CPU and the GPU setting.
- R5: When active configurations share the largest priority, the one with the lowest index is used.
- R6: The GPU level is a 2-bit code: 0 means none (0 % skipped), 1 means low (50 %), 2 means medium (75 %) and 3 means high (85 %).
- R7: The CPU field is a plain percentage. A value above 100 is treated as 100.
- R8: In each window, the number of cycles with a low enable equals the percentage latched for that window.
- R9: A setting that changes during a window does not alter the count of that window. It takes effect from the next window whose latch cycle comes at least one cycle after the change.
- R10: When the latched percentage is 50 or less, no two consecutive cycles of a window are skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_active | input | NUM_CFG | One request flag per configuration |
| cfg_prio | input | NUM_CFG*PRIO_W | Priority of each configuration, slice i at [i*PRIO_W +: PRIO_W] |
| cfg_cpu_pct | input | NUM_CFG*PCT_W | CPU skip percentage of each configuration, slice i at [i*PCT_W +: PCT_W] |
| cfg_gpu_lvl | input | NUM_CFG*2 | GPU skip level code of each configuration, slice i at [i*2 +: 2] |
| cpu_clk_en | output | 1 | Per-cycle enable for the CPU clock (0 = pulse skipped) |
| gpu_clk_en | output | 1 | Per-cycle enable for the GPU clock (0 = pulse skipped) |
| win_start | output | 1 | High in the first cycle of each skip window |

## Verification
The bench uses the default parameters: four configurations, 8-bit priorities and a 7-bit CPU field. Four slots are enough to hold a heavy, a light and an over-current request together with a fourth slot, which is used to build a priority tie. The 7-bit field can carry values up to 127, so the clamp at 100 can be reached. The 100-cycle window is short enough that every GPU code, the full-skip and no-skip limits, a tie, a priority swap and a change in the middle of a window each get a window of their own and are checked one after another.

// File: rtl/thr_pkg.sv
package thr_pkg;

  // Window length in cycles; also the accumulator modulus.
  localparam int FULL_SCALE = 100;
  localparam int PCT_BITS   = 7;
  localparam int ACC_BITS   = 8;

  typedef enum logic [1:0] {
    GLVL_NONE = 2'd0,
    GLVL_LOW  = 2'd1,
    GLVL_MED  = 2'd2,
    GLVL_HIGH = 2'd3
  } gpu_lvl_e;

  // Coded GPU level to skip percentage.
  function automatic logic [PCT_BITS-1:0] gpu_lvl_to_pct(input logic [1:0] lvl);
    case (gpu_lvl_e'(lvl))
      GLVL_LOW:  return PCT_BITS'(50);
      GLVL_MED:  return PCT_BITS'(75);
      GLVL_HIGH: return PCT_BITS'(85);
      default:   return '0;
    endcase
  endfunction

endpackage

// File: rtl/thr_window_timer.sv
module thr_window_timer
  import thr_pkg::*;
#(
  parameter int WIN_LEN = FULL_SCALE
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_first,
  output logic win_last
);
  localparam int PH_W = $clog2(WIN_LEN);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (phase_q == PH_W'(WIN_LEN - 1)) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign win_first = (phase_q == '0);
  assign win_last  = (phase_q == PH_W'(WIN_LEN - 1));

endmodule

// File: rtl/thr_arbiter.sv
module thr_arbiter
  import thr_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter int PRIO_W  = 8,
  parameter int PCT_W   = 7,
  localparam int IDX_W  = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CFG-1:0]        cfg_active,
  input  logic [NUM_CFG*PRIO_W-1:0] cfg_prio,
  input  logic [NUM_CFG*PCT_W-1:0]  cfg_cpu_pct,
  input  logic [NUM_CFG*2-1:0]      cfg_gpu_lvl,
  output logic                      sel_valid,
  output logic [IDX_W-1:0]          sel_idx,
  output logic [PCT_BITS-1:0]       sel_cpu_pct,
  output logic [1:0]                sel_gpu_lvl
);

  logic [PRIO_W-1:0]   prio_a [NUM_CFG];
  logic [PCT_BITS-1:0] cpu_a  [NUM_CFG];
  logic [1:0]          gpu_a  [NUM_CFG];

  // Unpack per-configuration fields; the CPU share is clamped to full scale.
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_unpack
    logic [PCT_W-1:0] raw;
    assign raw       = cfg_cpu_pct[g*PCT_W +: PCT_W];
    assign prio_a[g] = cfg_prio[g*PRIO_W +: PRIO_W];
    assign gpu_a[g]  = cfg_gpu_lvl[g*2 +: 2];
    assign cpu_a[g]  = (raw > PCT_W'(FULL_SCALE)) ? PCT_BITS'(FULL_SCALE)
                                                  : raw[PCT_BITS-1:0];
  end

  logic              win_found;
  logic [PRIO_W-1:0] win_prio;
  logic [IDX_W-1:0]  win_idx;

  // Strict greater-than keeps the lowest index on equal priority.
  always_comb begin
    win_found = 1'b0;
    win_prio  = '0;
    win_idx   = '0;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (cfg_active[i] && (!win_found || prio_a[i] > win_prio)) begin
        win_found = 1'b1;
        win_prio  = prio_a[i];
        win_idx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid   <= 1'b0;
      sel_idx     <= '0;
      sel_cpu_pct <= '0;
      sel_gpu_lvl <= '0;
    end else begin
      sel_valid   <= win_found;
      sel_idx     <= win_idx;
      sel_cpu_pct <= win_found ? cpu_a[win_idx] : '0;
      sel_gpu_lvl <= win_found ? gpu_a[win_idx] : '0;
    end
  end

endmodule

// File: rtl/thr_skip_engine.sv
module thr_skip_engine
  import thr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                win_last,
  input  logic [PCT_BITS-1:0] pct_in,
  output logic                clk_en,
  output logic [PCT_BITS-1:0] pct_lat
);

  logic [ACC_BITS-1:0] acc_q;
  logic [ACC_BITS-1:0] sum;
  logic                skip;

  assign sum    = acc_q + ACC_BITS'(pct_lat);
  assign skip   = (sum >= ACC_BITS'(FULL_SCALE));
  assign clk_en = ~skip;

  // Setting and accumulator restart together at each window boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      pct_lat <= '0;
    end else if (win_last) begin
      acc_q   <= '0;
      pct_lat <= pct_in;
    end else if (skip) begin
      acc_q   <= sum - ACC_BITS'(FULL_SCALE);
    end else begin
      acc_q   <= sum;
    end
  end

endmodule

// File: rtl/thr_pulse_skipper.sv
module thr_pulse_skipper
  import thr_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter int PRIO_W  = 8,
  parameter int PCT_W   = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CFG-1:0]        cfg_active,
  input  logic [NUM_CFG*PRIO_W-1:0] cfg_prio,
  input  logic [NUM_CFG*PCT_W-1:0]  cfg_cpu_pct,
  input  logic [NUM_CFG*2-1:0]      cfg_gpu_lvl,
  output logic                      cpu_clk_en,
  output logic                      gpu_clk_en,
  output logic                      win_start
);
  localparam int IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

  logic                win_last;
  logic                sel_valid;
  logic [IDX_W-1:0]    sel_idx;
  logic [PCT_BITS-1:0] sel_cpu_pct;
  logic [1:0]          sel_gpu_lvl;
  logic [PCT_BITS-1:0] sel_gpu_pct;
  logic [PCT_BITS-1:0] cpu_lat_pct;
  logic [PCT_BITS-1:0] gpu_lat_pct;

  thr_window_timer #(.WIN_LEN(FULL_SCALE)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_first (win_start),
    .win_last  (win_last)
  );

  thr_arbiter #(.NUM_CFG(NUM_CFG), .PRIO_W(PRIO_W), .PCT_W(PCT_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_active  (cfg_active),
    .cfg_prio    (cfg_prio),
    .cfg_cpu_pct (cfg_cpu_pct),
    .cfg_gpu_lvl (cfg_gpu_lvl),
    .sel_valid   (sel_valid),
    .sel_idx     (sel_idx),
    .sel_cpu_pct (sel_cpu_pct),
    .sel_gpu_lvl (sel_gpu_lvl)
  );

  assign sel_gpu_pct = gpu_lvl_to_pct(sel_gpu_lvl);

  thr_skip_engine u_cpu_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_last (win_last),
    .pct_in   (sel_cpu_pct),
    .clk_en   (cpu_clk_en),
    .pct_lat  (cpu_lat_pct)
  );

  thr_skip_engine u_gpu_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_last (win_last),
    .pct_in   (sel_gpu_pct),
    .clk_en   (gpu_clk_en),
    .pct_lat  (gpu_lat_pct)
  );

endmodule

// File: rtl/thr_pulse_skipper_chk.sv
module thr_pulse_skipper_chk
  import thr_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter int IDX_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CFG-1:0]  cfg_active,
  input logic                win_start,
  input logic                cpu_clk_en,
  input logic                gpu_clk_en,
  input logic                sel_valid,
  input logic [IDX_W-1:0]    sel_idx,
  input logic [PCT_BITS-1:0] cpu_lat_pct,
  input logic [PCT_BITS-1:0] gpu_lat_pct
);
  localparam int CW = $clog2(FULL_SCALE);

  logic [CW-1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cyc_q <= '0;
    else if (cyc_q == CW'(FULL_SCALE - 1)) cyc_q <= '0;
    else                                   cyc_q <= cyc_q + 1'b1;
  end

  assert_win_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_start == (cyc_q == '0));

  assert_zero_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_lat_pct == '0) |-> cpu_clk_en);

  assert_sel_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ((($past(cfg_active) >> sel_idx) & NUM_CFG'(1)) != '0));

  assert_gpu_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gpu_lat_pct == 7'd0) || (gpu_lat_pct == 7'd50) ||
    (gpu_lat_pct == 7'd75) || (gpu_lat_pct == 7'd85));

  assert_cpu_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_lat_pct <= PCT_BITS'(FULL_SCALE));

  assert_hold_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_start |-> ($stable(cpu_lat_pct) && $stable(gpu_lat_pct)));

  assert_cpu_spread_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && cpu_lat_pct <= 7'd50) |=> (win_start || cpu_clk_en));

  assert_gpu_spread_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!gpu_clk_en && gpu_lat_pct <= 7'd50) |=> (win_start || gpu_clk_en));

endmodule

bind thr_pulse_skipper thr_pulse_skipper_chk #(
  .NUM_CFG (NUM_CFG),
  .IDX_W   (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_active  (cfg_active),
  .win_start   (win_start),
  .cpu_clk_en  (cpu_clk_en),
  .gpu_clk_en  (gpu_clk_en),
  .sel_valid   (sel_valid),
  .sel_idx     (sel_idx),
  .cpu_lat_pct (cpu_lat_pct),
  .gpu_lat_pct (gpu_lat_pct)
);

// File: tb/thr_pulse_skipper_tb_top.sv
`timescale 1ns/1ps
module thr_pulse_skipper_tb_top;
  localparam int NC  = 4;
  localparam int PW  = 8;
  localparam int CW  = 7;
  localparam int WIN = 100;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NC-1:0]    act = '0;
  logic [NC*PW-1:0] prio = '0;
  logic [NC*CW-1:0] cpct = '0;
  logic [NC*2-1:0]  glvl = '0;
  logic             cpu_en, gpu_en, wstart;

  always #5 clk = ~clk;

  thr_pulse_skipper #(.NUM_CFG(NC), .PRIO_W(PW), .PCT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_active(act), .cfg_prio(prio),
    .cfg_cpu_pct(cpct), .cfg_gpu_lvl(glvl),
    .cpu_clk_en(cpu_en), .gpu_clk_en(gpu_en), .win_start(wstart)
  );

  typedef struct { int cpu; int gpu; string tag; } exp_t;
  exp_t q[$];
  int n_run = 0, n_fail = 0, done_cnt = 0;
  bit measuring = 0, summary_done = 0;

  function automatic void chk(bit ok, string tag, int a, int e);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endfunction

  task automatic set_cfg(int i, bit a, int p, int c, int g);
    act[i]           = a;
    prio[i*PW +: PW] = PW'(p);
    cpct[i*CW +: CW] = CW'(c);
    glvl[i*2 +: 2]   = 2'(g);
  endtask

  // Independent model of the selection rules (R4, R5, R6, R7).
  function automatic int lvl_pct(int l);
    case (l) 1: return 50; 2: return 75; 3: return 85; default: return 0; endcase
  endfunction

  task automatic model(output int ec, output int eg);
    int bp; bit f;
    f = 0; bp = 0; ec = 0; eg = 0;
    for (int i = 0; i < NC; i++) begin
      if (act[i] && (!f || int'(prio[i*PW +: PW]) > bp)) begin
        f = 1; bp = int'(prio[i*PW +: PW]);
        ec = int'(cpct[i*CW +: CW]); if (ec > 100) ec = 100;
        eg = lvl_pct(int'(glvl[i*2 +: 2]));
      end
    end
  endtask

  // Driver: pushes the expected counts of the next whole window.
  task automatic run_window(string tag, bit mid_change);
    exp_t it; int target;
    model(it.cpu, it.gpu);
    it.tag = tag;
    @(posedge clk); @(posedge clk); #1;
    target = done_cnt + 1;
    q.push_back(it);
    if (mid_change) begin
      wait (measuring);
      repeat (40) @(negedge clk);
      for (int i = 0; i < NC; i++) act[i] = 1'b0;
    end
    wait (done_cnt == target);
  endtask

  // Monitor: counts skipped pulses over one window and compares.
  initial begin
    exp_t cur; int nc, ng, cyc, dc, dg; bit pc, pg;
    nc = 0; ng = 0; cyc = 0; dc = 0; dg = 0; pc = 0; pg = 0;
    forever begin
      @(negedge clk);
      if (!measuring && rst_n && wstart && q.size() > 0) begin
        cur = q.pop_front();
        measuring = 1; cyc = 0; nc = 0; ng = 0; dc = 0; dg = 0; pc = 0; pg = 0;
      end
      if (measuring) begin
        if (cyc > 0) chk(!wstart, {cur.tag, " R2 no start mid-window"}, int'(wstart), 0);
        if (!cpu_en) begin nc++; if (pc) dc++; end
        if (!gpu_en) begin ng++; if (pg) dg++; end
        pc = !cpu_en; pg = !gpu_en;
        cyc++;
        if (cyc == WIN) begin
          chk(nc == cur.cpu, {cur.tag, " R8 cpu skips"}, nc, cur.cpu);
          chk(ng == cur.gpu, {cur.tag, " R8 gpu skips"}, ng, cur.gpu);
          if (cur.cpu <= 50) chk(dc == 0, {cur.tag, " R10 cpu back-to-back"}, dc, 0);
          if (cur.gpu <= 50) chk(dg == 0, {cur.tag, " R10 gpu back-to-back"}, dg, 0);
          measuring = 0;
          done_cnt++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, -1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    chk(cpu_en === 1'b1, "R1 cpu enable in reset", int'(cpu_en), 1);
    chk(gpu_en === 1'b1, "R1 gpu enable in reset", int'(gpu_en), 1);
    rst_n = 1'b1;
    #1;
    chk(wstart === 1'b1, "R1 start flag after reset", int'(wstart), 1);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!wstart);
    chk(gap == WIN, "R2 window length", gap, WIN);

    run_window("R3 idle", 0);
    set_cfg(0, 1, 100, 85, 3); run_window("R4 heavy alone", 0);
    set_cfg(1, 1, 80, 50, 1);  run_window("R4 heavy over light", 0);
    act[0] = 0;                run_window("R4 light alone", 0);
    set_cfg(2, 1, 50, 75, 2);  run_window("R4 light over overcurrent", 0);
    act[1] = 0;                run_window("R6 medium level", 0);
    act[2] = 0;
    set_cfg(1, 1, 80, 50, 1);
    set_cfg(3, 1, 80, 30, 0);  run_window("R5 tie lower index", 0);
    act[1] = 0;                run_window("R6 none level", 0);
    set_cfg(3, 1, 200, 30, 0); act[1] = 1; run_window("R4 priority swap", 0);
    act = '0;
    set_cfg(0, 1, 100, 100, 3); run_window("R7 full skip", 0);
    set_cfg(0, 1, 100, 120, 2); run_window("R7 clamp", 0);
    set_cfg(0, 1, 100, 0, 0);   run_window("R7 zero", 0);
    set_cfg(0, 1, 100, 37, 1);  run_window("R8 odd share", 0);
    set_cfg(0, 1, 100, 85, 3);  run_window("R9 change mid-window", 1);
    run_window("R9 next window idle", 0);

    summary_done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule